// File: doc/BRIEF.md
# Microwire-style serial master with slave-ready handshake

This block drives a half-duplex, three-wire-plus-select serial link. Each exchange opens with a control word sent most significant bit first on `txd`. One data frame follows. In write mode the master shifts the frame out on `txd`. In read mode it holds `txd` low and samples the slave's reply on `rxd`, which arrives as one leading dummy bit followed by the frame. A burst is several control/data pairs sent back to back, and the select stays low for the whole burst. Every parameter of a transfer is taken from the parallel inputs on the `start` cycle and is held until the transfer ends. Inputs changed later, and `start` pulses that arrive during a transfer, have no effect.

With the handshake enabled, the serial clock keeps running after each data frame while `txd` stays low. The master samples `rxd` on every rising edge and waits for the slave to report ready. After that it either sends the next control word or, after the last pair, sends one high start bit that clears the slave's ready state. A programmable limit ends a wait that lasts too long, and an error flag records this. The controller is a six-state machine:
- `ST_IDLE`: waits for `start`.
- `ST_CTRL`: shifts the control word. After its last bit it goes to `ST_DATA`.
- `ST_DATA`: moves the frame. After it, the machine goes to `ST_POLL` if the handshake is on. Otherwise it goes to `ST_CTRL` if pairs remain, or to `ST_TAIL`.
- `ST_POLL`: waits for ready. It then goes to `ST_CTRL` or `ST_STARTB`. It goes to `ST_TAIL` on timeout.
- `ST_STARTB`: sends the start bit for one serial clock period, then goes to `ST_TAIL`.
- `ST_TAIL`: holds for half a period, then releases the select and returns to `ST_IDLE`.

Top module: `mw_master`

## Requirements
- R1: After reset, and whenever the select is released, `sel_n` is 1, `sclk_out` is 0, `txd` is 0, and `busy`, `done` and `err` are 0.
- R2: The control word is sent first, `ctl_len`+1 bits long (1 to 16), most significant bit first, so the first bit is `ctl_word[ctl_len]`.
- R3: In write mode (`rd_mode`=0) the data frame follows the control word directly, `data_len`+1 bits long, most significant bit first. A `data_len` below 3 is treated as 3, which gives 4 bits.
- R4: In read mode (`rd_mode`=1) `txd` is held at 0 for a dummy bit plus the frame. The first sampled bit is discarded. The frame bits arrive most significant bit first and are right-aligned in `rd_data`, with the unused upper bits at 0. `rd_valid` pulses once per frame.
- R5: `txd` changes only while `sclk_out` is low, that is, on falling edges. `rxd` is sampled on rising edges.
- R6: `sclk_out` has a period of 2×`half_div` system clocks, and a `half_div` of 0 acts as 1. The first rising edge comes `half_div` clocks after `start` is taken.
- R7: A transfer carries `burst_len`+1 control/data pairs, and `sel_n` stays low between pairs.
- R8: With `hs_en`=1, the clock keeps running after each data frame with `txd` low. The master moves on only after the falling edge that follows a rising edge on which `rxd` was 1.
- R9: With `hs_en`=1, once the final ready has been seen, one bit with `txd`=1 is sent before the release.
- R10: `sel_n` rises `half_div` system clocks after the last falling edge of `sclk_out`.
- R11: `busy` is high from the clock after `start` until the select is released. `done` is a single-cycle pulse in the first cycle that `busy` is low.
- R12: If the master waits for ready for `ready_limit` system clocks, the transfer is aborted. `sclk_out` drops, the select is released and `err` is set. `err` clears when the next transfer starts.
- R13: `start` and every configuration input are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| ctl_word | input | WORD_W | Control word |
| ctl_len | input | LEN_W | Control word length minus one |
| wr_data | input | WORD_W | Frame written in write mode |
| data_len | input | LEN_W | Frame length minus one (minimum 3) |
| rd_mode | input | 1 | 0 write frame, 1 read frame |
| hs_en | input | 1 | Enable slave-ready handshake |
| burst_len | input | BURST_W | Number of pairs minus one |
| half_div | input | DIV_W | Half serial period in system clocks |
| ready_limit | input | TO_W | Ready wait limit in system clocks |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | End-of-transfer pulse |
| err | output | 1 | Ready wait timed out |
| rd_data | output | WORD_W | Last frame read, right-aligned |
| rd_valid | output | 1 | Pulse when `rd_data` is updated |
| sclk_out | output | 1 | Serial clock, idles low |
| txd | output | 1 | Serial data to slave |
| rxd | input | 1 | Serial data and ready status from slave |
| sel_n | output | 1 | Active-low slave select |

## Verification
The bench keeps the default widths: 16-bit words, a 4-bit burst count, an 8-bit divider and a 16-bit ready limit. This lets every control and frame length from 1 and 4 up to 16, plus the 17-bit read with its dummy bit, appear within a few hundred clocks. `half_div` is drawn from 0 to 3, so the treatment of 0 as 1 is exercised, and short periods keep bursts of up to four handshaked pairs quick. One run uses a `ready_limit` of 60 against a slave that never becomes ready, so the abort path comes within reach. The following run confirms that `err` clears when that run starts.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_DATA,
        ST_POLL,
        ST_STARTB,
        ST_TAIL
    } mw_state_e;

    typedef enum logic [1:0] {
        TXS_LOW,
        TXS_HIGH,
        TXS_SHIFT
    } mw_txsrc_e;

endpackage

// File: rtl/mw_tick.sv
module mw_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    // a zero divider behaves like one
    assign lim  = (half == '0) ? DIV_W'(1) : half;
    assign tick = run && (cnt == lim - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/mw_shift.sv
module mw_shift #(
    parameter int WORD_W = 16,
    localparam int LEN_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              shift,
    input  logic              capture,
    input  logic              rx_bit,
    output logic              tx_msb,
    output logic [WORD_W-1:0] rx_word
);
    localparam logic [LEN_W-1:0] TOP = LEN_W'(WORD_W - 1);

    logic [WORD_W-1:0] tx_sh;
    logic [WORD_W-1:0] rx_sh;

    assign tx_msb  = tx_sh[WORD_W-1];
    assign rx_word = rx_sh;

    // left-align the word so its top bit sits at the output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tx_sh <= '0;
        else if (load)
            tx_sh <= load_word << (TOP - load_len);
        else if (shift)
            tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rx_sh <= '0;
        else if (capture)
            rx_sh <= {rx_sh[WORD_W-2:0], rx_bit};
    end
endmodule

// File: rtl/mw_fsm.sv
module mw_fsm
    import mw_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int BURST_W = 4,
    parameter int TO_W    = 16,
    localparam int LEN_W  = $clog2(WORD_W),
    localparam int CW     = LEN_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               tick,
    input  logic               rxd,
    input  logic               rd_mode,
    input  logic               hs_en,
    input  logic [LEN_W-1:0]   cl,
    input  logic [LEN_W-1:0]   dl,
    input  logic [BURST_W-1:0] burst,
    input  logic [TO_W-1:0]    to_lim,
    output logic               busy,
    output logic               sclk,
    output logic               sel_n,
    output logic               done,
    output logic               err,
    output logic               rx_valid,
    output logic               ld_ctl,
    output logic               ld_dat,
    output logic               shift,
    output logic               capture,
    output mw_txsrc_e          txsrc
);
    mw_state_e          state, nxt;
    logic [CW-1:0]      bcnt;
    logic [BURST_W-1:0] pairs;
    logic [TO_W-1:0]    to_cnt;
    logic               rdy;
    logic               rise, fall, last_bit, more, expired, clk_on;

    assign rise     = tick && !sclk;
    assign fall     = tick && sclk;
    assign last_bit = (bcnt == '0);
    assign more     = (pairs != '0);
    assign expired  = (state == ST_POLL) && (to_cnt >= to_lim);
    assign clk_on   = (state == ST_CTRL) || (state == ST_DATA) ||
                      (state == ST_POLL) || (state == ST_STARTB);
    assign busy     = (state != ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_CTRL;
            ST_CTRL:   if (fall && last_bit) nxt = ST_DATA;
            ST_DATA: begin
                if (fall && last_bit) begin
                    if (hs_en)     nxt = ST_POLL;
                    else if (more) nxt = ST_CTRL;
                    else           nxt = ST_TAIL;
                end
            end
            ST_POLL: begin
                if (expired)          nxt = ST_TAIL;
                else if (fall && rdy) nxt = more ? ST_CTRL : ST_STARTB;
            end
            ST_STARTB: if (fall) nxt = ST_TAIL;
            ST_TAIL:   if (tick) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // strobes toward the shifter and the txd source
    assign ld_ctl  = (nxt == ST_CTRL) && (state != ST_CTRL);
    assign ld_dat  = (state == ST_CTRL) && (nxt == ST_DATA) && !rd_mode;
    assign shift   = fall && !last_bit &&
                     ((state == ST_CTRL) || ((state == ST_DATA) && !rd_mode));
    assign capture = rise && (state == ST_DATA) && rd_mode;

    always_comb begin
        txsrc = TXS_LOW;
        unique case (state)
            ST_CTRL:   txsrc = TXS_SHIFT;
            ST_DATA:   txsrc = rd_mode ? TXS_LOW : TXS_SHIFT;
            ST_STARTB: txsrc = TXS_HIGH;
            default:   txsrc = TXS_LOW;
        endcase
    end

    // registered outputs and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk     <= 1'b0;
            sel_n    <= 1'b1;
            done     <= 1'b0;
            err      <= 1'b0;
            rx_valid <= 1'b0;
            bcnt     <= '0;
            pairs    <= '0;
            rdy      <= 1'b0;
            to_cnt   <= '0;
        end else begin
            done     <= (state == ST_TAIL) && tick;
            rx_valid <= (state == ST_DATA) && fall && last_bit && rd_mode;

            if (state == ST_IDLE && start) begin
                sel_n <= 1'b0;
                err   <= 1'b0;
                pairs <= burst;
            end
            if (state == ST_TAIL && tick)
                sel_n <= 1'b1;

            if (expired) begin
                err  <= 1'b1;
                sclk <= 1'b0;
            end else if (tick && clk_on) begin
                sclk <= ~sclk;
            end

            if (ld_ctl) begin
                bcnt <= {1'b0, cl};
                if (state != ST_IDLE)
                    pairs <= pairs - BURST_W'(1);
            end else if (state == ST_CTRL && nxt == ST_DATA) begin
                bcnt <= rd_mode ? ({1'b0, dl} + CW'(1)) : {1'b0, dl};
            end else if (fall && !last_bit && (state == ST_CTRL || state == ST_DATA)) begin
                bcnt <= bcnt - CW'(1);
            end

            if (nxt == ST_POLL && state != ST_POLL) begin
                rdy    <= 1'b0;
                to_cnt <= '0;
            end else if (state == ST_POLL) begin
                to_cnt <= to_cnt + TO_W'(1);
                if (rise)
                    rdy <= rxd;
            end
        end
    end
endmodule

// File: rtl/mw_master.sv
module mw_master
    import mw_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int BURST_W = 4,
    parameter int DIV_W   = 8,
    parameter int TO_W    = 16,
    localparam int LEN_W  = $clog2(WORD_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WORD_W-1:0]  ctl_word,
    input  logic [LEN_W-1:0]   ctl_len,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [LEN_W-1:0]   data_len,
    input  logic               rd_mode,
    input  logic               hs_en,
    input  logic [BURST_W-1:0] burst_len,
    input  logic [DIV_W-1:0]   half_div,
    input  logic [TO_W-1:0]    ready_limit,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [WORD_W-1:0]  rd_data,
    output logic               rd_valid,
    output logic               sclk_out,
    output logic               txd,
    input  logic               rxd,
    output logic               sel_n
);
    localparam logic [LEN_W-1:0] TOP  = LEN_W'(WORD_W - 1);
    localparam logic [LEN_W-1:0] DMIN = LEN_W'(3);

    // configuration held for the whole transfer
    logic [WORD_W-1:0]  ctl_q, dat_q;
    logic [LEN_W-1:0]   cl_q, dl_q;
    logic               dir_q, hs_q;
    logic [BURST_W-1:0] bu_q;
    logic [DIV_W-1:0]   div_q;
    logic [TO_W-1:0]    to_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0; dat_q <= '0; cl_q <= '0; dl_q <= DMIN;
            dir_q <= 1'b0; hs_q <= 1'b0; bu_q <= '0; div_q <= '0; to_q <= '0;
        end else if (!busy && start) begin
            ctl_q <= ctl_word; dat_q <= wr_data; cl_q <= ctl_len;
            dl_q  <= (data_len < DMIN) ? DMIN : data_len;
            dir_q <= rd_mode; hs_q <= hs_en; bu_q <= burst_len;
            div_q <= half_div; to_q <= ready_limit;
        end
    end

    // live inputs on the start cycle, held copies afterwards
    logic [WORD_W-1:0]  cur_ctl, cur_dat;
    logic [LEN_W-1:0]   cur_cl, cur_dl;
    logic               cur_dir, cur_hs;
    logic [BURST_W-1:0] cur_bu;
    logic [DIV_W-1:0]   cur_div;
    logic [TO_W-1:0]    cur_to;

    assign cur_ctl = busy ? ctl_q : ctl_word;
    assign cur_dat = busy ? dat_q : wr_data;
    assign cur_cl  = busy ? cl_q  : ctl_len;
    assign cur_dl  = busy ? dl_q  : ((data_len < DMIN) ? DMIN : data_len);
    assign cur_dir = busy ? dir_q : rd_mode;
    assign cur_hs  = busy ? hs_q  : hs_en;
    assign cur_bu  = busy ? bu_q  : burst_len;
    assign cur_div = busy ? div_q : half_div;
    assign cur_to  = busy ? to_q  : ready_limit;

    logic              tick, ld_ctl, ld_dat, shift, capture, tx_msb;
    logic [WORD_W-1:0] rx_word;
    mw_txsrc_e         txsrc;

    mw_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .half (cur_div),
        .tick (tick)
    );

    mw_shift #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_ctl || ld_dat),
        .load_word(ld_ctl ? cur_ctl : cur_dat),
        .load_len (ld_ctl ? cur_cl : cur_dl),
        .shift    (shift),
        .capture  (capture),
        .rx_bit   (rxd),
        .tx_msb   (tx_msb),
        .rx_word  (rx_word)
    );

    mw_fsm #(.WORD_W(WORD_W), .BURST_W(BURST_W), .TO_W(TO_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tick    (tick),
        .rxd     (rxd),
        .rd_mode (cur_dir),
        .hs_en   (cur_hs),
        .cl      (cur_cl),
        .dl      (cur_dl),
        .burst   (cur_bu),
        .to_lim  (cur_to),
        .busy    (busy),
        .sclk    (sclk_out),
        .sel_n   (sel_n),
        .done    (done),
        .err     (err),
        .rx_valid(rd_valid),
        .ld_ctl  (ld_ctl),
        .ld_dat  (ld_dat),
        .shift   (shift),
        .capture (capture),
        .txsrc   (txsrc)
    );

    always_comb begin
        unique case (txsrc)
            TXS_SHIFT: txd = tx_msb;
            TXS_HIGH:  txd = 1'b1;
            default:   txd = 1'b0;
        endcase
    end

    // the dummy bit and any older bits fall outside the mask
    assign rd_data = rx_word & ({WORD_W{1'b1}} >> (TOP - dl_q));
endmodule

// File: rtl/mw_master_chk.sv
module mw_master_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic err,
    input logic sclk_out,
    input logic sel_n,
    input logic txd
);
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> !sclk_out); // R1

    AST_TXD_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_out |-> $stable(txd)); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R11

    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R11

    AST_IDLE_SEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sel_n); // R11

    AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> !err); // R12
endmodule

bind mw_master mw_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .err     (err),
    .sclk_out(sclk_out),
    .sel_n   (sel_n),
    .txd     (txd)
);

// File: tb/sim_mw_master.sv
`timescale 1ns/1ps
module sim_mw_master;
    localparam int PL = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] ctl_word = '0, wr_data = '0;
    logic [3:0]  ctl_len = '0, data_len = '0, burst_len = '0;
    logic        rd_mode = 1'b0, hs_en = 1'b0;
    logic [7:0]  half_div = '0;
    logic [15:0] ready_limit = '0;
    logic        busy, done, err, rd_valid, sclk_out, txd, sel_n;
    logic [15:0] rd_data;
    logic        rxd = 1'b0;

    always #2.5 clk = ~clk;

    mw_master u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ctl_word(ctl_word),
        .ctl_len(ctl_len), .wr_data(wr_data), .data_len(data_len),
        .rd_mode(rd_mode), .hs_en(hs_en), .burst_len(burst_len),
        .half_div(half_div), .ready_limit(ready_limit), .busy(busy),
        .done(done), .err(err), .rd_data(rd_data), .rd_valid(rd_valid),
        .sclk_out(sclk_out), .txd(txd), .rxd(rxd), .sel_n(sel_n)
    );

    int total = 0, bad = 0, cyc = 0;
    bit exp_tx[PL];
    bit plan_rx[PL];
    bit got_tx[PL];
    int n_exp, ridx, rv_n, done_n, per_bad, hold_bad;
    int last_rise, last_fall, sel_rel, div_eff;
    bit first_rise = 1'b1, p_sclk = 1'b0, p_sel = 1'b1, p_txd = 1'b0;
    logic [15:0] rd_exp[8];
    logic [15:0] rd_got[8];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // slave model and edge monitor, sampled between clock edges
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (sclk_out && txd != p_txd) hold_bad++;
            if (sclk_out && !p_sclk) begin
                if (ridx < PL) got_tx[ridx] = txd;
                if (!first_rise && (cyc - last_rise) != 2 * div_eff) per_bad++;
                first_rise = 1'b0;
                last_rise  = cyc;
                ridx++;
            end
            if (!sclk_out && p_sclk) begin
                last_fall = cyc;
                rxd = (ridx < PL) ? plan_rx[ridx] : 1'b0;
            end
            if (sel_n && !p_sel) sel_rel = cyc;
            if (rd_valid) begin
                if (rv_n < 8) rd_got[rv_n] = rd_data;
                rv_n++;
            end
            if (done) done_n++;
        end
        p_sclk = sclk_out;
        p_sel  = sel_n;
        p_txd  = txd;
    end

    task automatic push(input bit e, input bit r);
        if (n_exp < PL) begin
            exp_tx[n_exp]  = e;
            plan_rx[n_exp] = r;
        end
        n_exp++;
    endtask

    // expected per-rising-edge txd and the slave's rxd plan
    task automatic build_plan(input logic [15:0] c, input int cl, input logic [15:0] d,
                              input int dle, input bit dr, input bit hs, input int bu,
                              input int w);
        n_exp = 0;
        for (int i = 0; i < PL; i++) begin exp_tx[i] = 1'b0; plan_rx[i] = 1'b0; end
        for (int p = 0; p <= bu; p++) begin
            logic [31:0] rv;
            rv = $urandom;
            rd_exp[p] = rv[15:0] & ((dle == 15) ? 16'hFFFF : ((16'h1 << (dle + 1)) - 16'h1));
            for (int i = cl; i >= 0; i--) push(c[i], 1'b0);
            if (!dr) begin
                for (int i = dle; i >= 0; i--) push(d[i], 1'b0);
            end else begin
                push(1'b0, 1'b0);
                for (int i = dle; i >= 0; i--) push(1'b0, rd_exp[p][i]);
            end
            if (hs) begin
                for (int k = 0; k < w; k++) push(1'b0, 1'b0);
                push(1'b0, 1'b1);
            end
        end
        if (hs) push(1'b1, 1'b0);
    endtask

    task automatic run_xfer(input logic [15:0] c, input int cl, input logic [15:0] d,
                            input int dl, input bit dr, input bit hs, input int bu,
                            input int dv, input int w, input int tol, input bit expect_to);
        int dle, wc, mism;
        logic [31:0] r;
        dle     = (dl < 3) ? 3 : dl;
        div_eff = (dv == 0) ? 1 : dv;
        build_plan(c, cl, d, dle, dr, hs, bu, w);
        ridx = 0; rv_n = 0; done_n = 0; per_bad = 0; hold_bad = 0;
        first_rise = 1'b1; last_fall = 0; sel_rel = 0;
        rxd = plan_rx[0];
        ctl_word = c; ctl_len = cl[3:0]; wr_data = d; data_len = dl[3:0];
        rd_mode = dr; hs_en = hs; burst_len = bu[3:0]; half_div = dv[7:0];
        ready_limit = tol[15:0];
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1, "R11 busy after start", int'(busy), 1);
        chk(err == 1'b0, "R12 err cleared at start", int'(err), 0);
        // R13: scramble every input and restart mid-transfer
        r = $urandom; ctl_word = r[15:0]; wr_data = r[31:16];
        r = $urandom; ctl_len = r[3:0]; data_len = r[7:4]; burst_len = r[11:8];
        rd_mode = ~dr; hs_en = ~hs; half_div = r[19:12]; ready_limit = r[31:16];
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        wc = 0;
        while (!done && wc < 20000) begin @(negedge clk); wc++; end
        @(negedge clk);
        chk(wc < 20000, "R11 transfer finished", wc, 20000);
        chk(done_n == 1, "R13 one done despite restart", done_n, 1);
        chk(!busy && sel_n && !sclk_out && !txd, "R1 idle after transfer",
            int'({busy, sel_n, sclk_out, txd}), 4);
        if (expect_to) begin
            chk(err == 1'b1, "R12 timeout sets err", int'(err), 1);
        end else begin
            mism = 0;
            for (int i = 0; i < n_exp && i < PL; i++) if (got_tx[i] != exp_tx[i]) mism++;
            chk(ridx == n_exp, "R7 R8 rising edge count", ridx, n_exp);
            chk(mism == 0, "R2 R3 R4 R8 txd bit sequence", mism, 0);
            if (hs) chk(got_tx[n_exp - 1] == 1'b1, "R9 trailing start bit",
                        int'(got_tx[n_exp - 1]), 1);
            chk(per_bad == 0, "R6 sclk period", per_bad, 0);
            chk(hold_bad == 0, "R5 txd steady while sclk high", hold_bad, 0);
            chk(sel_rel - last_fall == div_eff, "R10 select release delay",
                sel_rel - last_fall, div_eff);
            chk(err == 1'b0, "R12 no error", int'(err), 0);
            chk(rv_n == (dr ? bu + 1 : 0), "R4 read frame count", rv_n, dr ? bu + 1 : 0);
            if (dr) for (int p = 0; p <= bu && p < 8; p++)
                chk(rd_got[p] == rd_exp[p], "R4 read data", int'(rd_got[p]), int'(rd_exp[p]));
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R11 act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] a, b;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(sel_n && !sclk_out && !txd && !busy && !done && !err, "R1 reset state",
            int'({sel_n, sclk_out, txd, busy, done, err}), 32);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // directed corners
        run_xfer(16'hA5C3, 15, 16'h5AF0, 15, 1'b0, 1'b0, 0, 1, 0, 16'hFFFF, 1'b0);
        run_xfer(16'h0001, 0, 16'h0000, 1, 1'b1, 1'b1, 2, 2, 0, 16'hFFFF, 1'b0);
        run_xfer(16'h3C3C, 7, 16'h0000, 15, 1'b1, 1'b1, 1, 3, 2, 16'hFFFF, 1'b0);
        run_xfer(16'h00F5, 3, 16'hBEEF, 0, 1'b0, 1'b0, 3, 0, 0, 16'hFFFF, 1'b0);
        run_xfer(16'h0123, 5, 16'h0ABC, 11, 1'b0, 1'b1, 0, 2, 600, 60, 1'b1);
        run_xfer(16'h00AA, 7, 16'h0055, 7, 1'b0, 1'b1, 0, 1, 1, 16'hFFFF, 1'b0);

        // constrained random
        for (int t = 0; t < 30; t++) begin
            a = $urandom; b = $urandom;
            run_xfer(a[15:0], int'(b[3:0]), a[31:16], int'(b[7:4]), b[8], b[9],
                     int'(b[11:10]), int'(b[13:12]), int'(b[15:14]), 16'hFFFF, 1'b0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule